// File: doc/BRIEF.md
# Dual-Clock FIFO with Per-Slot Occupancy Flags

This block carries data words from a producer clock domain to a consumer clock domain. The two clocks may run at any frequencies and phases relative to each other. Each storage slot has one occupancy flag. The flag is formed as the XOR of a toggle bit owned by the writer and a toggle bit owned by the reader. The flag vector is sampled on the falling edge of each destination clock, and those samples produce `full` on the write side and `empty` on the read side. Write and read slot selection use one-hot ring counters, so no pointer value ever crosses between the domains.

The read port is first-word fall-through. While `empty` is low, `rd_data` presents the oldest word, and raising `rd_en` consumes it at the next rising read edge. The producer raises `wr_en` with `wr_data` and the word is taken at a rising write edge unless `full` is high.

`full` is raised a configurable number of slots before true capacity. This reserve absorbs writes that a fast producer issues before it can observe a slow consumer's state. Between the two limits the block accepts one write per write cycle and one read per read cycle without any synchronisation stall.

Top module: `mcfifo_slotsync`

## Requirements
- R1: While either reset is held, and right after both are released, `empty` is 1 and `full` is 0.
- R2: Words leave in the order they were accepted, with none lost and none duplicated, across several wraps of the ring counters.
- R3: A write attempted while `full` is 1 is ignored: that word never appears at the read port, and the stored words are unchanged.
- R4: A read attempted while `empty` is 1 is ignored: a word written afterwards is still delivered intact.
- R5: From an empty queue, a written word makes `empty` low no later than the second rising read edge after the write edge.
- R6: With reads idle, `full` is 0 after K accepted writes for K < DEPTH - FULL_MARGIN, and `full` is 1 once K reaches DEPTH - FULL_MARGIN (it is updated at the next falling write edge).
- R7: Once words are visible to the reader, they can be read on consecutive rising read edges without `empty` rising in between.
- R8: An accepted write never targets a slot whose occupancy flag is still set.
- R9: Each ring counter is one-hot at all times and advances by exactly one slot per accepted operation, wrapping at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer clock |
| wrst_n | input | 1 | Producer-side asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | Early full indication, write-clock synchronous |
| rclk | input | 1 | Consumer clock |
| rrst_n | input | 1 | Consumer-side asynchronous reset, active low |
| rd_en | input | 1 | Read request (consumes the word on rd_data) |
| rd_data | output | DATA_W | Oldest stored word |
| empty | output | 1 | No visible word, read-clock synchronous |

## Verification
The bench streams long sequences under three read-clock periods. One of them is a consumer more than three times slower than the producer. A full-threshold or flag-sampling error under this load shows up as a dropped, repeated or reordered word.

Two tests fill the queue with the reader stopped. They check that `full` rises at exactly DEPTH - FULL_MARGIN words, and that writes attempted while `full` is high stay out of the data stream. A design that stored such a word would deliver an extra word afterwards.

Reads attempted on an empty queue, and the first-word latency, are checked directly at the ports. A design that moved its read ring on an ignored read would return the wrong slot's data.

A burst read of words already written exposes any needless stall between consecutive reads.

// File: rtl/mcfifo_slotsync.sv
module mcfifo_slotsync #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 8,
  parameter int FULL_MARGIN = 2
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty
);
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FULL_AT = DEPTH - FULL_MARGIN;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  wr_ring, rd_ring, wtog, rtog, occ, occ_w, occ_r;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              wr_ok, rd_ok;

  assign occ   = wtog ^ rtog;
  assign wr_ok = wr_en & ~full;
  assign rd_ok = rd_en & ~empty;

  always_comb begin
    wr_idx = '0;
    rd_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_ring[i]) wr_idx = i[IDX_W-1:0];
      if (rd_ring[i]) rd_idx = i[IDX_W-1:0];
    end
  end

  // producer domain
  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wr_ring <= DEPTH'(1);
      wtog    <= '0;
    end else if (wr_ok) begin
      wr_ring <= {wr_ring[DEPTH-2:0], wr_ring[DEPTH-1]};
      wtog    <= wtog ^ wr_ring;
    end

  always_ff @(posedge wclk)
    if (wr_ok) mem[wr_idx] <= wr_data;

  always_ff @(negedge wclk or negedge wrst_n)
    if (!wrst_n) occ_w <= '0;
    else         occ_w <= occ;

  assign full = ($countones(occ_w) >= FULL_AT) | (|(occ_w & wr_ring));

  // consumer domain
  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rd_ring <= DEPTH'(1);
      rtog    <= '0;
    end else if (rd_ok) begin
      rd_ring <= {rd_ring[DEPTH-2:0], rd_ring[DEPTH-1]};
      rtog    <= rtog ^ rd_ring;
    end

  always_ff @(negedge rclk or negedge rrst_n)
    if (!rrst_n) occ_r <= '0;
    else         occ_r <= occ;

  assign empty   = ~|(occ_r & rd_ring);
  assign rd_data = mem[rd_idx];

  // checks
  p_no_occupied_write_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_ok |-> !(|(occ & wr_ring)));
  p_read_hits_valid_r2: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_ok |-> |(occ & rd_ring));
  p_wring_onehot_r9: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wr_ring) == 1);
  p_rring_onehot_r9: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rd_ring) == 1);
  p_full_ignores_write_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && full) |=> ($stable(wtog) && $stable(wr_ring)));
  p_empty_ignores_read_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && empty) |=> ($stable(rtog) && $stable(rd_ring)));
endmodule

// File: tb/tb_mcfifo_slotsync.sv
`timescale 1ns/1ps
module tb_mcfifo_slotsync;
  localparam int DW = 8, DEPTH = 8, MARGIN = 2, FULL_AT = DEPTH - MARGIN;

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0, wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic full, empty;
  real rhalf = 3.5;
  int errors = 0, checks = 0, pop_waits = 0;

  mcfifo_slotsync #(.DATA_W(DW), .DEPTH(DEPTH), .FULL_MARGIN(MARGIN)) dut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data), .empty(empty));

  always #2.5 wclk = ~wclk;
  always #(rhalf) rclk = ~rclk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_en = 0; rd_en = 0; wrst_n = 0; rrst_n = 0;
    repeat (3) @(posedge rclk);
    repeat (3) @(posedge wclk);
    #1;
    chk("R1 empty in reset", empty, 1);
    chk("R1 full in reset", full, 0);
    @(negedge wclk); wrst_n = 1;
    @(negedge rclk); rrst_n = 1;
  endtask

  task automatic push(input logic [DW-1:0] d);
    forever begin
      @(negedge wclk); #1;
      if (!full) begin
        wr_en = 1; wr_data = d;
        @(posedge wclk); #1;
        wr_en = 0;
        break;
      end
    end
  endtask

  task automatic pop(output logic [DW-1:0] d);
    forever begin
      @(negedge rclk); #1;
      if (!empty) begin
        rd_en = 1; d = rd_data;
        @(posedge rclk); #1;
        rd_en = 0;
        break;
      end
      pop_waits++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    repeat (2) @(negedge wclk);
    #1;
    chk("R1 full after reset", full, 0);
    @(negedge rclk); #1;
    chk("R1 empty after reset", empty, 1);
  endtask

  task automatic t_first_word();
    logic [DW-1:0] d;
    do_reset();
    push(8'h5A);
    @(posedge rclk); @(posedge rclk); #1;
    chk("R5 empty low by second read edge", empty, 0);
    pop(d);
    chk("R5 first word data", d, 8'h5A);
  endtask

  task automatic t_empty_read();
    logic [DW-1:0] d;
    do_reset();
    @(negedge rclk); #1; rd_en = 1;
    repeat (4) @(posedge rclk);
    #1; rd_en = 0;
    chk("R4 still empty after ignored reads", empty, 1);
    push(8'hC3);
    push(8'h3C);
    pop(d); chk("R4 word after ignored reads", d, 8'hC3);
    pop(d); chk("R4 second word", d, 8'h3C);
    repeat (3) @(posedge rclk);
    @(negedge rclk); #1;
    chk("R4 empty again", empty, 1);
  endtask

  task automatic t_early_full();
    logic [DW-1:0] d;
    do_reset();
    for (int k = 1; k <= FULL_AT; k++) begin
      push(8'h10 + k[7:0]);
      @(negedge wclk); #1;
      chk($sformatf("R6 full after %0d writes", k), full, (k >= FULL_AT) ? 1 : 0);
    end
    @(negedge wclk); #1; wr_en = 1; wr_data = 8'hEE;
    repeat (3) @(posedge wclk);
    #1; wr_en = 0;
    chk("R3 full held during ignored writes", full, 1);
    for (int k = 1; k <= FULL_AT; k++) begin
      pop(d);
      chk($sformatf("R3 stored word %0d", k), d, 8'h10 + k[7:0]);
    end
    repeat (3) @(posedge rclk);
    @(negedge rclk); #1;
    chk("R3 ignored word absent", empty, 1);
    repeat (3) @(negedge wclk);
    #1;
    chk("R6 full clears after drain", full, 0);
  endtask

  task automatic t_burst_read();
    logic [DW-1:0] d;
    do_reset();
    for (int k = 0; k < 5; k++) push(8'hA0 + k[7:0]);
    repeat (3) @(posedge rclk);
    pop_waits = 0;
    for (int k = 0; k < 5; k++) begin
      pop(d);
      chk("R7 burst data", d, 8'hA0 + k[7:0]);
    end
    chk("R7 no stall between reads", pop_waits, 0);
  endtask

  task automatic t_stream(input real half, input int n);
    int bad = 0;
    do_reset();
    rhalf = half;
    fork
      for (int i = 0; i < n; i++) push(8'(i * 37 + 5));
      for (int i = 0; i < n; i++) begin
        logic [DW-1:0] d;
        pop(d);
        if (d !== 8'(i * 37 + 5)) begin
          if (bad == 0) chk($sformatf("R2 stream word %0d", i), d, 8'(i * 37 + 5));
          bad++;
        end
      end
    join
    chk($sformatf("R2 R8 R9 stream half=%0.2f mismatches", half), bad, 0);
    repeat (4) @(posedge rclk);
    @(negedge rclk); #1;
    chk("R2 empty after stream", empty, 1);
    rhalf = 3.5;
  endtask

  initial begin
    t_reset();
    t_first_word();
    t_empty_read();
    t_early_full();
    t_burst_read();
    t_stream(8.5, 60);
    t_stream(1.65, 60);
    t_stream(3.55, 60);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule